// File: doc/BRIEF.md
# Password-Guarded GPIO Bank Register File

This block is the register file of a general-purpose I/O controller. It serves a parameterised number of banks (one to eight), each carrying 32 pins. Software reaches it over a plain 32-bit register bus with byte addresses, one word per access. Every pin has its own control word, and bit 0 of that word chooses the pin's direction. Every bank has an output latch that software changes only through a write-one-to-set port and a write-one-to-clear port. Software can read the latch and the already-synchronised pad inputs back.

A per-bank lock word gives every pin a lock bit. While a pin's lock bit is 1, its control word and its output latch bit cannot be changed. Software changes a lock word only by writing a fixed key to the key register and making the lock write as the very next bus write. Reads are never blocked. Synchronisation, interrupts, debounce and the pads themselves are handled outside this block.

Top module: `gpio_lock_regs`

## Requirements
- R1: After reset every pin is an input (pad_dir_in all ones, control word bit 0 reads 1), every output latch bit is 0, and every lock word reads 0xFFFFFFFF.
- R2: A write to the set port of bank b (byte address 0x040 + 4b) sets each latch bit of that bank where the data has a 1 and the pin is unlocked. All other bits are unchanged.
- R3: A write to the clear port of bank b (0x060 + 4b) clears each latch bit of that bank where the data has a 1 and the pin is unlocked. All other bits are unchanged.
- R4: The control word of pin p is at byte address 0x100 + 4p, where p = 32·bank + bit. A write to it sets the pin's direction from data bit 0 (1 = input, 0 = output), and reading it returns that bit in bit 0 with zeros above.
- R5: The lock word of bank b is at 0x500 + 4b (a 1 bit locks that pin). A write to it takes effect only if the previous bus write put 0x00A5A501 into the key register at 0x520. A key write with any other value arms nothing.
- R6: The next bus write uses up the key, whatever that write is. A lock write after any other write is dropped. Reads do not use up the key.
- R7: For a pin whose lock bit is 1, writes to its control word and to its set or clear bit have no effect.
- R8: A read returns its data on bus_rdata one cycle after bus_rd_en. The output status of bank b (0x000 + 4b) returns the latch, the input status (0x020 + 4b) returns pad_in of that bank, and the set, clear and key registers read as 0.
- R9: Addresses of banks or pins at or above the configured count read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd_en |
| pad_in | input | 32·NUM_BANKS | Synchronised pad input levels |
| pad_out | output | 32·NUM_BANKS | Output latch of every pin |
| pad_dir_in | output | 32·NUM_BANKS | Pin direction, 1 = input |

## Verification
A lock word corrupted inside the block shows up on the next read of that lock address. It also shows up in the cycle after the next set, clear or control write, as a pad_out or pad_dir_in bit that moved when it should have held, or held when it should have moved. An arming flag stuck high or cleared too early is visible only through a lock write: the lock readback one cycle later differs from the expected value. For that reason the bench brackets every lock write with key writes, other writes, reads and wrong keys. A wrong address decode puts the wrong bank's value on bus_rdata one cycle after the read, or moves a pad bit in another bank.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
   localparam int unsigned PINS_PER_BANK = 32;
   localparam int unsigned MAX_BANKS     = 8;
   localparam int unsigned BUS_AW        = 12;
   localparam int unsigned BUS_DW        = 32;
   localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h00A5_A501;

   typedef enum logic [2:0] {
      RG_NONE, RG_OUT, RG_IN, RG_SET, RG_CLR, RG_CTRL, RG_LOCK, RG_KEY
   } reg_kind_e;
endpackage

// File: rtl/gpio_lock_decode.sv
module gpio_lock_decode
   import gpio_lock_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8
) (
   input  logic [BUS_AW-1:0] addr,
   output reg_kind_e         kind,
   output logic [2:0]        bank_idx,
   output logic [7:0]        pin_idx,
   output logic              bank_ok,
   output logic              pin_ok
);
   localparam int unsigned NPINS = NUM_BANKS * PINS_PER_BANK;

   logic [9:0] word;
   logic       unused_lsb;

   assign word       = addr[11:2];
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      kind     = RG_NONE;
      bank_idx = addr[4:2];
      pin_idx  = word[7:0] - 8'd64;
      unique case (addr[11:5])
         7'h00: kind = RG_OUT;
         7'h01: kind = RG_IN;
         7'h02: kind = RG_SET;
         7'h03: kind = RG_CLR;
         7'h28: kind = RG_LOCK;
         7'h29: kind = (addr[4:2] == 3'd0) ? RG_KEY : RG_NONE;
         default: begin
            if (addr[11:8] >= 4'd1 && addr[11:8] <= 4'd4) kind = RG_CTRL;
         end
      endcase
   end

   assign bank_ok = ({29'd0, bank_idx} < 32'(NUM_BANKS));
   assign pin_ok  = ({24'd0, pin_idx} < 32'(NPINS));
endmodule

// File: rtl/gpio_lock_guard.sv
module gpio_lock_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic key_hit,
   output logic armed
);
   always_ff @(posedge clk) begin
      if (!rst_n)     armed <= 1'b0;
      else if (wr_en) armed <= key_hit;
   end
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] wdata,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic         lock_req,
   input  logic         arm_i,
   input  logic [W-1:0] ctrl_we,
   output logic [W-1:0] out_q,
   output logic [W-1:0] lock_q,
   output logic [W-1:0] dir_q
);
   logic [W-1:0] open_bits;
   assign open_bits = ~lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         lock_q <= '1;
      end else begin
         if (lock_req && arm_i) lock_q <= wdata;
         if (set_we)      out_q <= out_q | (wdata & open_bits);
         else if (clr_we) out_q <= out_q & ~(wdata & open_bits);
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_dir
      always_ff @(posedge clk) begin
         if (!rst_n)                           dir_q[i] <= 1'b1;
         else if (ctrl_we[i] && open_bits[i])  dir_q[i] <= wdata[0];
      end
   end

   // R2
   set_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((out_q & $past(wdata & ~lock_q)) == $past(wdata & ~lock_q)));
   // R3
   clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((out_q & $past(wdata & ~lock_q)) == '0));
   // R7
   locked_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((out_q ^ $past(out_q)) & $past(lock_q)) == '0));
   // R7
   locked_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((dir_q ^ $past(dir_q)) & $past(lock_q)) == '0));
   // R5
   lock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_q) |-> $past(arm_i && lock_req));
endmodule

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs
   import gpio_lock_pkg::*;
#(
   parameter  int unsigned NUM_BANKS = 8,
   localparam int unsigned NPINS     = NUM_BANKS * PINS_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_dir_in
);
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int unsigned PIN_W  = $clog2(NPINS);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("gpio_lock_regs: NUM_BANKS must lie in 1..8");
   end

   reg_kind_e  kind;
   logic [2:0] bank_idx;
   logic [7:0] pin_idx;
   logic       bank_ok, pin_ok;
   logic       key_hit, armed;

   gpio_lock_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .addr(bus_addr), .kind(kind), .bank_idx(bank_idx),
      .pin_idx(pin_idx), .bank_ok(bank_ok), .pin_ok(pin_ok)
   );

   assign key_hit = bus_wr_en && (kind == RG_KEY) && (bus_wdata == UNLOCK_KEY);

   gpio_lock_guard u_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en),
      .key_hit(key_hit), .armed(armed)
   );

   logic [PINS_PER_BANK-1:0] out_b  [NUM_BANKS];
   logic [PINS_PER_BANK-1:0] lock_b [NUM_BANKS];
   logic [PINS_PER_BANK-1:0] in_b   [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic                     hit_b;
      logic                     ctrl_hit;
      logic [PINS_PER_BANK-1:0] ctrl_we_b;

      assign hit_b     = bank_ok && (bank_idx == 3'(b));
      assign ctrl_hit  = bus_wr_en && (kind == RG_CTRL) && pin_ok && (pin_idx[7:5] == 3'(b));
      assign ctrl_we_b = ctrl_hit ? (PINS_PER_BANK'(1) << pin_idx[4:0]) : '0;
      assign in_b[b]   = pad_in[b*PINS_PER_BANK +: PINS_PER_BANK];

      gpio_lock_bank #(.W(PINS_PER_BANK)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wdata   (bus_wdata),
         .set_we  (bus_wr_en && (kind == RG_SET)  && hit_b),
         .clr_we  (bus_wr_en && (kind == RG_CLR)  && hit_b),
         .lock_req(bus_wr_en && (kind == RG_LOCK) && hit_b),
         .arm_i   (armed),
         .ctrl_we (ctrl_we_b),
         .out_q   (out_b[b]),
         .lock_q  (lock_b[b]),
         .dir_q   (pad_dir_in[b*PINS_PER_BANK +: PINS_PER_BANK])
      );

      assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_b[b];
   end

   logic [BANK_W-1:0] bsel;
   logic [PIN_W-1:0]  psel;
   logic [BUS_DW-1:0] rd_mux;

   assign bsel = bank_idx[BANK_W-1:0];
   assign psel = pin_idx[PIN_W-1:0];

   always_comb begin
      rd_mux = '0;
      unique case (kind)
         RG_OUT:  if (bank_ok) rd_mux = out_b[bsel];
         RG_IN:   if (bank_ok) rd_mux = in_b[bsel];
         RG_LOCK: if (bank_ok) rd_mux = lock_b[bsel];
         RG_CTRL: if (pin_ok)  rd_mux = {31'd0, pad_dir_in[psel]};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   // R8
   wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && (kind == RG_SET || kind == RG_CLR || kind == RG_KEY)) |=> (bus_rdata == '0));
   // R9
   range_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && (kind == RG_OUT || kind == RG_LOCK) && !bank_ok) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_lock_regs.sv
`timescale 1ns/1ps
module tb_gpio_lock_regs;
   localparam int NB = 2;
   localparam int NP = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_dir_in;

   int  n_chk = 0, n_err = 0;
   bit  done = 1'b0;
   bit  rd_seen = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   gpio_lock_regs #(.NUM_BANKS(NB)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_dir_in(pad_dir_in)
   );

   task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      exp_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   // monitor: one cycle read latency
   always @(posedge clk) rd_seen <= bus_rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         exp_t it;
         if (sb_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R8 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            it = sb_q.pop_front();
            check64({32'd0, bus_rdata}, {32'd0, it.exp}, it.tag);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check64(pad_dir_in, '1, "R1 dir after reset");
      check64(pad_out, '0, "R1 out after reset");
      rd(12'h500, 32'hFFFF_FFFF, "R1 lock bank0");
      rd(12'h504, 32'hFFFF_FFFF, "R1 lock bank1");
      rd(12'h114, 32'h1, "R1 ctrl pin5");
      // R7 locked pins ignore writes
      wr(12'h10C, 32'h0);
      check64(pad_dir_in, '1, "R7 ctrl write on locked pin");
      wr(12'h040, 32'h0000_000F);
      check64(pad_out, '0, "R7 set write on locked pins");
      // R5 lock without key, with wrong key, then with key
      wr(12'h500, 32'h0);
      rd(12'h500, 32'hFFFF_FFFF, "R5 lock write without key");
      wr(12'h520, 32'h1234_5678);
      wr(12'h500, 32'h0);
      rd(12'h500, 32'hFFFF_FFFF, "R5 lock write after wrong key");
      wr(12'h520, 32'h00A5_A501);
      wr(12'h500, 32'hFFFF_0000);
      rd(12'h500, 32'hFFFF_0000, "R5 lock write after key");
      // R6 key used up by any write, not by reads
      wr(12'h520, 32'h00A5_A501);
      wr(12'h040, 32'h0);
      wr(12'h500, 32'h0);
      rd(12'h500, 32'hFFFF_0000, "R6 key consumed by set write");
      wr(12'h520, 32'h00A5_A501);
      rd(12'h000, 32'h0, "R6 read between key and lock");
      wr(12'h504, 32'h0);
      rd(12'h504, 32'h0, "R6 read does not consume key");
      // R4 direction via control words
      wr(12'h108, 32'h0);
      wr(12'h150, 32'h0);
      check64(pad_dir_in, {32'hFFFF_FFFF, 32'hFFFF_FFFB}, "R4 pin2 output, pin20 locked");
      rd(12'h108, 32'h0, "R4 ctrl pin2 readback");
      wr(12'h108, 32'hFFFF_FFFF);
      rd(12'h108, 32'h1, "R4 ctrl pin2 back to input");
      wr(12'h108, 32'h0);
      // R2 set
      wr(12'h040, 32'h0030_00FF);
      check64(pad_out, {32'h0, 32'h0000_00FF}, "R2 set unlocked bits only");
      rd(12'h000, 32'h0000_00FF, "R8 out status bank0");
      rd(12'h040, 32'h0, "R8 set reads zero");
      // R3 clear
      wr(12'h060, 32'h0000_000F);
      check64(pad_out, {32'h0, 32'h0000_00F0}, "R3 clear");
      wr(12'h520, 32'h00A5_A501);
      wr(12'h500, 32'h0);
      wr(12'h040, 32'h0010_0000);
      check64(pad_out, {32'h0, 32'h0010_00F0}, "R2 set after unlock");
      wr(12'h520, 32'h00A5_A501);
      wr(12'h500, 32'hFFFF_0000);
      wr(12'h060, 32'h0010_00F0);
      check64(pad_out, {32'h0, 32'h0010_0000}, "R3 clear skips locked bit");
      // R8 input status and write-only registers
      pad_in = {32'hDEAD_BEEF, 32'h1357_9BDF};
      rd(12'h020, 32'h1357_9BDF, "R8 in status bank0");
      rd(12'h024, 32'hDEAD_BEEF, "R8 in status bank1");
      rd(12'h060, 32'h0, "R8 clear reads zero");
      rd(12'h520, 32'h0, "R8 key reads zero");
      // bank1 unlocked earlier
      wr(12'h044, 32'h8000_0001);
      rd(12'h004, 32'h8000_0001, "R2 set bank1");
      // R9 out of range
      rd(12'h00C, 32'h0, "R9 out status bank3");
      rd(12'h290, 32'h0, "R9 ctrl pin100");
      wr(12'h048, 32'hFFFF_FFFF);
      wr(12'h290, 32'h0);
      check64(pad_out, {32'h8000_0001, 32'h0010_0000}, "R9 set to missing bank");
      check64(pad_dir_in, {32'hFFFF_FFFF, 32'hFFFF_FFFB}, "R9 ctrl to missing pin");
      repeat (3) @(negedge clk);
      check64(64'(sb_q.size()), 64'd0, "R8 all reads returned");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule